// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out a single multi-register move. A 16-bit mask selects which of sixteen registers take part: eight data registers (D0 to D7) and eight address registers (A0 to A7). The block either stores the chosen registers to memory or loads them from memory. The caller supplies the following with a one-cycle `start` pulse:

- the direction;
- the operand size (word or long);
- a 3-bit addressing-mode class;
- a precomputed effective address;
- the index of the base address register.

The block reads the register file through one combinational read port and writes it through one write port. Memory is reached through a 16-bit word interface with a valid/ready handshake, so a long operand needs two memory requests.

When the walk through the mask ends, the block writes the final address to the base address register, but only in the auto-modify modes. It then raises `done` for one cycle. Together with `done` it reports the overhead cycle count that the move costs outside the data transfers. A request whose mode does not suit its direction is refused: `illegal` is raised with `done` and nothing else happens.

Top module: `regmask_mover`

## Requirements
- R1: In every mode except predecrement stores, mask bit i selects register i. Indices 0..7 are D0..D7 and indices 8..15 are A0..A7, and they are visited from bit 0 upward. Loads write register i.
- R2: In a predecrement store (mode 2), mask bit i selects register 15-i. Bit 0 is therefore A7 and bit 15 is D0, still visited from bit 0 upward.
- R3: Each selected register moves 2 bytes at word size and 4 bytes at long size. Predecrement stores subtract the size before each transfer. All other modes add the size after each transfer.
- R4: A long store first writes bits 15:0 at address+2, then bits 31:16 at address. A long load first reads address (bits 31:16), then address+2 (bits 15:0). A word transfer uses bits 15:0 at address.
- R5: A word load sign-extends bit 15 of the memory word into a full 32-bit register write. This applies to data and address registers alike.
- R6: The final address is written to register 8+base only for predecrement stores and postincrement loads (mode 1), in the done cycle. This write wins over any load of the same register. Every other mode leaves the base register untouched.
- R7: The overhead count is reported with done. It is 8 for stores or 4 for loads, plus a mode term, plus 4 prefetch cycles. The mode term is 4 for displacement (mode 3), 6 for indexed (mode 4), 4 for absolute short (mode 5), 8 for absolute long (mode 6), and 0 for modes 0..2.
- R8: A load with mode 2, a store with mode 1, or any request with mode 7 is illegal. It raises `illegal` together with `done` in the cycle after start, issues no memory request, writes no register and reports overhead 0.
- R9: Clear mask bits cause no memory request and no address change. An all-zero mask completes with no memory traffic.
- R10: While `mem_valid` is high and `mem_ready` is low, address, write data and direction stay unchanged in the next cycle.
- R11: `done` lasts one cycle and the block is idle afterwards. `start` is ignored while busy. After reset the block is idle with no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| store | input | 1 | 1: registers to memory, 0: memory to registers |
| long_sz | input | 1 | 1: long (32-bit), 0: word (16-bit) |
| mode | input | 3 | Addressing class (0 indirect, 1 postinc, 2 predec, 3 disp, 4 indexed, 5 abs short, 6 abs long, 7 reserved) |
| mask | input | 16 | Register selection mask |
| ea | input | 32 | Precomputed effective address |
| base | input | 3 | Base address register index (A0..A7) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request refused, valid with done |
| ovh | output | 5 | Overhead cycle count, valid with done |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1: write request, 0: read request |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the accepting cycle |

## Verification
The assertions take for granted that the memory side drives `mem_ready` as a plain acceptance of the current request. They also assume that read data is valid in the same cycle as `mem_ready`, and that the register file answers reads combinationally. The bench keeps to this with a memory model that answers only while a request is valid. Its ready pattern varies between always-ready and periodic stalls. Starts are issued only from idle, apart from one deliberate start during a busy run. Between starts the request inputs are scrambled to show that they are sampled once. Effective addresses are kept inside the model's 512-byte window.

// File: rtl/regmask_mover.sv
module regmask_mover #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          store,
  input  logic          long_sz,
  input  logic [2:0]    mode,
  input  logic [15:0]   mask,
  input  logic [AW-1:0] ea,
  input  logic [2:0]    base,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [4:0]    ovh,
  output logic [3:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [3:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int IW = $clog2(NREG) + 1;
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_XFER, S_FIN} st_t;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [15:0]    msk;
  logic           st_q, lg_q, half, ill_q;
  logic [2:0]     md_q, bs_q;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  data;
  logic [4:0]     ovh_new;
  logic [3:0]     mode_term;

  wire predec  = (md_q == 3'd2);
  wire postinc = (md_q == 3'd1);
  wire bad_req = (mode == 3'd7) || (mode == 3'd2 && !store) || (mode == 3'd1 && store);
  wire [AW-1:0] step = lg_q ? AW'(4) : AW'(2);
  wire last   = !lg_q || half;
  wire wb     = !ill_q && ((predec && st_q) || (postinc && !st_q));
  wire hs     = (st == S_XFER) && mem_ready;
  wire upper  = lg_q && (st_q ? !half : half);

  always_comb begin
    case (mode)
      3'd3:    mode_term = 4'd4;
      3'd4:    mode_term = 4'd6;
      3'd5:    mode_term = 4'd4;
      3'd6:    mode_term = 4'd8;
      default: mode_term = 4'd0;
    endcase
    ovh_new = (store ? 5'd8 : 5'd4) + 5'(mode_term) + 5'd4;
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign illegal   = done && ill_q;
  assign rf_raddr  = (st_q && predec) ? 4'(NREG - 1) - idx[3:0] : idx[3:0];
  assign mem_valid = (st == S_XFER);
  assign mem_write = st_q;
  assign mem_addr  = upper ? addr + AW'(2) : addr;
  assign mem_wdata = (lg_q && half) ? data[DW-1:HW] : data[HW-1:0];
  assign rf_we     = (hs && !st_q && last) || (done && wb);
  assign rf_waddr  = done ? {1'b1, bs_q} : idx[3:0];
  assign rf_wdata  = done ? DW'(addr) :
                     lg_q ? {data[DW-1:HW], mem_rdata} : {{HW{mem_rdata[15]}}, mem_rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      msk   <= '0;
      st_q  <= 1'b0;
      lg_q  <= 1'b0;
      half  <= 1'b0;
      ill_q <= 1'b0;
      md_q  <= '0;
      bs_q  <= '0;
      addr  <= '0;
      data  <= '0;
      ovh   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st_q  <= store;
          lg_q  <= long_sz;
          md_q  <= mode;
          bs_q  <= base;
          msk   <= mask;
          addr  <= ea;
          idx   <= '0;
          ill_q <= bad_req;
          ovh   <= bad_req ? 5'd0 : ovh_new;
          st    <= bad_req ? S_FIN : S_SCAN;
        end
        S_SCAN: begin
          if (idx[IW-1]) begin
            st <= S_FIN;
          end else if (msk[idx[3:0]]) begin
            if (st_q) data <= rf_rdata;
            if (predec) addr <= addr - step;
            half <= 1'b0;
            st   <= S_XFER;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_XFER: if (mem_ready) begin
          if (!last) begin
            half <= 1'b1;
            if (!st_q) data[DW-1:HW] <= mem_rdata;
          end else begin
            if (!predec) addr <= addr + step;
            idx <= idx + 1'b1;
            st  <= S_SCAN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module regmask_mover_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        rf_we,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !rf_we); // R11
  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !rf_we && !mem_valid); // R8
  AST_WB_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !mem_valid |-> done); // R6
endmodule

bind regmask_mover regmask_mover_chk chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .rf_we(rf_we), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_regmask_mover.sv
module tb_regmask_mover;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, store = 1'b0, long_sz = 1'b0;
  logic [2:0] mode = '0, base = '0;
  logic [15:0] mask = '0;
  logic [31:0] ea = '0;
  logic busy, done, illegal, rf_we, mem_valid, mem_write;
  logic [4:0] ovh;
  logic [3:0] rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr;
  logic mem_ready = 1'b0;
  logic [15:0] mem_wdata, mem_rdata = '0;

  logic [31:0] rf [16];
  logic [15:0] mem [256];
  logic [48:0] q[$];
  int total = 0, bad = 0, cyc = 0, rdy_pat = 4;
  string cur_req = "R1";
  bit stall_seen = 0;
  logic [48:0] stall_req;

  always #2 clk = ~clk;

  regmask_mover dut (
    .clk(clk), .rst_n(rst_n), .start(start), .store(store), .long_sz(long_sz),
    .mode(mode), .mask(mask), .ea(ea), .base(base), .busy(busy), .done(done),
    .illegal(illegal), .ovh(ovh), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: ready generation, request hold check, scoreboard pop
  always @(negedge clk) begin
    logic [48:0] cur, e;
    cyc++;
    mem_ready = rst_n && ((cyc % 4) < rdy_pat);
    cur = {mem_write, mem_addr, mem_write ? mem_wdata : 16'h0};
    if (stall_seen)
      chk(mem_valid && cur == stall_req, "R10", "held request", cur, stall_req);
    if (mem_valid && mem_ready) begin
      if (q.size() == 0) begin
        chk(0, cur_req, "unexpected request", cur, 0);
      end else begin
        e = q.pop_front();
        chk(cur == e, cur_req, "request", cur, e);
      end
      if (mem_write) mem[mem_addr[8:1]] = mem_wdata;
      mem_rdata = mem[mem_addr[8:1]];
    end
    stall_seen = mem_valid && !mem_ready;
    stall_req = cur;
  end

  task automatic run_op(string tag, bit st, bit lg, bit [2:0] md, bit [15:0] mk,
                        bit [31:0] ea_v, bit [2:0] bs, bit poke);
    logic [31:0] e[16];
    logic [31:0] a = ea_v, v;
    int sz = lg ? 4 : 2;
    int n = 0, xo;
    bit ill = (md == 7) || (md == 2 && !st) || (md == 1 && st);
    for (int i = 0; i < 16; i++) e[i] = rf[i];
    cur_req = tag;
    if (!ill) begin
      for (int i = 0; i < 16; i++) if (mk[i]) begin
        if (st) begin
          int r = (md == 2) ? 15 - i : i;
          if (md == 2) a = a - sz;
          v = rf[r];
          if (lg) begin
            q.push_back({1'b1, a + 32'd2, v[15:0]});
            q.push_back({1'b1, a, v[31:16]});
          end else q.push_back({1'b1, a, v[15:0]});
          if (md != 2) a = a + sz;
        end else begin
          if (lg) begin
            q.push_back({1'b0, a, 16'h0});
            q.push_back({1'b0, a + 32'd2, 16'h0});
            e[i] = {mem[a[8:1]], mem[a[8:1] + 8'd1]};
          end else begin
            q.push_back({1'b0, a, 16'h0});
            e[i] = {{16{mem[a[8:1]][15]}}, mem[a[8:1]]};
          end
          a = a + sz;
        end
      end
      if ((md == 2 && st) || (md == 1 && !st)) e[8 + bs] = a;
    end
    case (md)
      3: xo = 4; 4: xo = 6; 5: xo = 4; 6: xo = 8; default: xo = 0;
    endcase
    xo = ill ? 0 : (st ? 8 : 4) + xo + 4;
    @(negedge clk);
    start = 1; store = st; long_sz = lg; mode = md; mask = mk; ea = ea_v; base = bs;
    @(negedge clk);
    start = 0; mask = ~mk; ea = 32'h1F0; mode = 3'd0; store = ~st; base = ~bs;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; mode = 3'd0; mask = 16'hFFFF; store = 1;  // R11: ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, tag, "done seen", done, 1);
    chk(illegal == ill, ill ? "R8" : tag, "illegal flag", illegal, ill);
    chk(ovh == xo, "R7", "overhead", ovh, xo);
    @(negedge clk);
    chk(!done && !busy, "R11", "single done then idle", {done, busy}, 0);
    chk(q.size() == 0, tag, "missing requests", q.size(), 0);
    for (int i = 0; i < 16; i++)
      chk(rf[i] == e[i], tag, $sformatf("reg %0d", i), rf[i], e[i]);
    q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1111_0000 * (i + 1) + 32'h8000 * (i % 2) + i;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h2F3B) ^ 16'h4007;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid && !rf_we, "R11", "reset idle", {busy, done, mem_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    run_op("R1", 1, 1, 3'd0, 16'h8103, 32'h40, 3'd2, 0);     // R4 long store order
    run_op("R2", 1, 0, 3'd2, 16'h0081, 32'h80, 3'd3, 0);     // R6 predec writeback
    rdy_pat = 2;
    mem[8'h31] = 16'h8765;
    run_op("R5", 0, 0, 3'd1, 16'h2404, 32'h60, 3'd5, 0);     // R6 postinc writeback, R10 stalls
    rdy_pat = 4;
    run_op("R3", 0, 1, 3'd6, 16'hF00F, 32'h100, 3'd1, 0);    // R6 no writeback
    run_op("R9", 1, 1, 3'd3, 16'h0000, 32'h20, 3'd0, 0);
    rdy_pat = 3;
    run_op("R11", 1, 0, 3'd4, 16'h5555, 32'hC0, 3'd6, 1);
    rdy_pat = 4;
    run_op("R8", 0, 0, 3'd2, 16'hFFFF, 32'h40, 3'd0, 0);
    run_op("R8", 1, 1, 3'd1, 16'h00F0, 32'h40, 3'd1, 0);
    run_op("R8", 1, 0, 3'd7, 16'h0001, 32'h40, 3'd2, 0);
    run_op("R6", 0, 1, 3'd1, 16'h0C01, 32'h140, 3'd2, 0);    // base A2 loaded then overwritten
    run_op("R1", 1, 0, 3'd5, 16'hA00A, 32'h1A0, 3'd4, 0);
    run_op("R2", 1, 1, 3'd2, 16'h8001, 32'h1E0, 3'd7, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule